// File: doc/BRIEF.md
# Interrupt request pin controller

This block collects a set of event inputs into sticky status bits and drives a single interrupt request pin from them. Each general event input, one copy-protection detector source and a software stimulus strobe each own a status bit. A status bit is set on the rising edge of its source and stays set until software writes a one to its clear bit. A per-bit enable mask decides which status bits may raise the pin. The software stimulus bit is always enabled.

A single configuration byte selects three things. The first is how long the pin stays active: one of three fixed lengths counted in clock periods, or held until software clears or masks the cause. The second is which copy-protection detections count as a source. The third is how the pin is driven: open drain, driven low when active, or driven high when active. An assertion is started only when no enabled status bit is already pending. Software must therefore read every status bit after it services a request. The pin is presented as an output-enable and value pair for the pad. After reset the pin does not drive, and no source is enabled.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the configuration reads 8'h10 (length code 00, source select 01, drive code 00), all mask enables are 0, all status bits are 0 and irq_oe is 0. An event with its enable at 0 sets its status bit but never activates the pin.
- R2: Status bit i (general events at bits 0..N_GEN-1) is set on the clock after a rising edge of its input and stays set until cleared. A level that stays high does not set it again.
- R3: Writing irq_clr with bit i at 1 clears status bit i on the next clock. If a new event for bit i arrives in the same cycle, the set wins.
- R4: Length codes 00, 01 and 10 keep the pin active for exactly PULSE_A, PULSE_B and PULSE_C clock periods (defaults 3, 15 and 63). The pin becomes active on the first clock after the triggering edge.
- R5: With length code 11 the pin is active whenever any enabled status bit is set, and it stays active after the source input falls. It releases on the clock that clears or masks the last enabled pending bit.
- R6: Drive code 00 (open drain) gives irq_oe equal to the active state with irq_val 0. The reserved code 11 behaves exactly like 00.
- R7: Drive code 01 gives irq_oe=1 and irq_val equal to the inverse of the active state. Drive code 10 gives irq_oe=1 and irq_val equal to the active state.
- R8: An enabled event that arrives while another enabled status bit is still set does not start a new assertion. Its status bit is still recorded.
- R9: Once no enabled status bit remains set, including one cleared in the same cycle, the next enabled event starts a full-length fresh assertion.
- R10: A one-cycle pulse on sw_stim sets status bit N_GEN+1, which is always enabled regardless of the mask, and starts an assertion like any event.
- R11: Status bit N_GEN takes the rising edge of the selected copy-protection level. Select 00 selects none, 01 the pseudo-sync detector, 10 the colour-stripe detector and 11 either one.
- R12: The configuration byte holds the length code in bits [7:6], the source select in [5:4] and the drive code in [1:0]. Bits [3:2] are stored and read back. A write is visible on cfg_rd one clock later. Mask bit i at 1 enables status bit i, with bit N_GEN for the copy-protection source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write data |
| mask_wr | input | 1 | Mask enable write strobe |
| mask_wdata | input | N_GEN+1 | Per-bit enables, 1 = may raise the pin |
| irq_clr | input | N_GEN+2 | Write-one-to-clear strobes for the status bits |
| sw_stim | input | 1 | Software stimulus strobe |
| evt_in | input | N_GEN | General event levels |
| cp_pseudo | input | 1 | Pseudo-sync detector level |
| cp_stripe | input | 1 | Colour-stripe detector level |
| cfg_rd | output | 8 | Configuration byte read back |
| status | output | N_GEN+2 | Sticky status bits |
| irq_oe | output | 1 | Pin output enable |
| irq_val | output | 1 | Pin output value |

## Verification
The bench builds the block with N_GEN=3 and the default lengths of 3, 15 and 63 periods. This gives five status bits, so suppression can be shown with two general bits pending at once. The copy-protection and stimulus bits sit at known positions, 3 and 4. With these defaults even the longest fixed pulse is short enough to be checked cycle by cycle in every drive mode.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'b00,
    LEN_MID   = 2'b01,
    LEN_LONG  = 2'b10,
    LEN_HOLD  = 2'b11
  } len_code_e;

  typedef enum logic [1:0] {
    DRV_OPEN     = 2'b00,
    DRV_ACT_LOW  = 2'b01,
    DRV_ACT_HIGH = 2'b10,
    DRV_RSVD     = 2'b11
  } drv_code_e;

  // Field order follows the bit positions of the configuration byte.
  typedef struct packed {
    len_code_e  len;
    logic [1:0] cp_sel;
    logic [1:0] spare;
    drv_code_e  drv;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{len: LEN_SHORT, cp_sel: 2'b01,
                                     spare: 2'b00, drv: DRV_OPEN};

  localparam int CP_SEL_PSEUDO = 0;
  localparam int CP_SEL_STRIPE = 1;

endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture import irq_pin_pkg::*; #(
  parameter int N_GEN = 4,
  localparam int NS = N_GEN + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_GEN-1:0] evt_in,
  input  logic             cp_pseudo,
  input  logic             cp_stripe,
  input  logic [1:0]       cp_sel,
  input  logic             sw_stim,
  output logic [NS-1:0]    rise
);

  logic [N_GEN-1:0] evt_q;
  logic             cp_lvl;
  logic             cp_q;

  // One edge detector per general event input.
  for (genvar gi = 0; gi < N_GEN; gi++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) evt_q[gi] <= 1'b0;
      else     evt_q[gi] <= evt_in[gi];
    end
    assign rise[gi] = evt_in[gi] & ~evt_q[gi];
  end

  // The selected copy-protection detectors merge into one level.
  assign cp_lvl = (cp_sel[CP_SEL_PSEUDO] & cp_pseudo) |
                  (cp_sel[CP_SEL_STRIPE] & cp_stripe);

  always_ff @(posedge clk) begin
    if (rst) cp_q <= 1'b0;
    else     cp_q <= cp_lvl;
  end

  assign rise[N_GEN]   = cp_lvl & ~cp_q;
  assign rise[N_GEN+1] = sw_stim;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] rise,
  input  logic [NS-1:0] clr,
  input  logic [NS-1:0] en_q,
  input  logic [NS-1:0] en_d,
  output logic [NS-1:0] status_q,
  output logic          trig,
  output logic          pend_nxt
);

  logic [NS-1:0] status_d;
  logic [NS-1:0] kept;
  logic          pend_left;

  assign kept     = status_q & ~clr;
  assign status_d = kept | rise;

  // Pending after this cycle's clears; a new edge may only start a
  // pulse when nothing enabled is left waiting.
  assign pend_left = |(kept & en_q);
  assign trig      = (|(rise & en_q)) & ~pend_left;
  assign pend_nxt  = |(status_d & en_d);

  for (genvar bi = 0; bi < NS; bi++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) status_q[bi] <= 1'b0;
      else     status_q[bi] <= status_d[bi];
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
      rise[bi] |=> status_q[bi]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (clr[bi] && !rise[bi]) |=> !status_q[bi]);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      (status_q[bi] && !clr[bi]) |=> status_q[bi]);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
      (!status_q[bi] && !rise[bi]) |=> !status_q[bi]);
  end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PULSE_A = 3,
  parameter int PULSE_B = 15,
  parameter int PULSE_C = 63,
  localparam int LMAX = (PULSE_A > PULSE_B) ? ((PULSE_A > PULSE_C) ? PULSE_A : PULSE_C)
                                            : ((PULSE_B > PULSE_C) ? PULSE_B : PULSE_C),
  localparam int CW = $clog2(LMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic [1:0] len_code,
  input  logic       trig,
  input  logic       pend_nxt,
  output logic       active
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  always_comb begin
    case (len_code)
      2'b00:   reload = CW'(PULSE_A - 1);
      2'b01:   reload = CW'(PULSE_B - 1);
      2'b10:   reload = CW'(PULSE_C - 1);
      default: reload = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (hold) begin
      active <= pend_nxt;
      cnt_q  <= '0;
    end else if (trig) begin
      active <= 1'b1;
      cnt_q  <= reload;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_pulse_end_R4: assert property (@(posedge clk) disable iff (rst)
    (!hold && active && cnt_q == '0 && !trig) |=> !active);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LMAX - 1));
  assert_fresh_load_R9: assert property (@(posedge clk) disable iff (rst)
    (!hold && trig) |=> active);

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv import irq_pin_pkg::*; (
  input  drv_code_e drv,
  input  logic      active,
  output logic      oe,
  output logic      val
);

  always_comb begin
    case (drv)
      DRV_ACT_LOW: begin
        oe  = 1'b1;
        val = ~active;
      end
      DRV_ACT_HIGH: begin
        oe  = 1'b1;
        val = active;
      end
      default: begin
        // Open drain and the reserved code: pull low only while active.
        oe  = active;
        val = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl import irq_pin_pkg::*; #(
  parameter int N_GEN   = 4,
  parameter int PULSE_A = 3,
  parameter int PULSE_B = 15,
  parameter int PULSE_C = 63,
  localparam int NM = N_GEN + 1,
  localparam int NS = N_GEN + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  input  logic             mask_wr,
  input  logic [NM-1:0]    mask_wdata,
  input  logic [NS-1:0]    irq_clr,
  input  logic             sw_stim,
  input  logic [N_GEN-1:0] evt_in,
  input  logic             cp_pseudo,
  input  logic             cp_stripe,
  output logic [7:0]       cfg_rd,
  output logic [NS-1:0]    status,
  output logic             irq_oe,
  output logic             irq_val
);

  irq_cfg_t      cfg_q;
  logic [NM-1:0] mask_q;
  logic [NM-1:0] mask_d;
  logic [NS-1:0] en_q;
  logic [NS-1:0] en_d;
  logic [NS-1:0] rise;
  logic          trig;
  logic          pend_nxt;
  logic          hold;
  logic          irq_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RESET;
      mask_q <= '0;
    end else begin
      if (cfg_wr)  cfg_q  <= irq_cfg_t'(cfg_wdata);
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  assign mask_d = mask_wr ? mask_wdata : mask_q;
  // The stimulus bit cannot be masked.
  assign en_q   = {1'b1, mask_q};
  assign en_d   = {1'b1, mask_d};
  assign hold   = (cfg_q.len == LEN_HOLD);
  assign cfg_rd = cfg_q;

  irq_evt_capture #(.N_GEN(N_GEN)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .evt_in    (evt_in),
    .cp_pseudo (cp_pseudo),
    .cp_stripe (cp_stripe),
    .cp_sel    (cfg_q.cp_sel),
    .sw_stim   (sw_stim),
    .rise      (rise)
  );

  irq_status_bank #(.NS(NS)) u_status (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .clr      (irq_clr),
    .en_q     (en_q),
    .en_d     (en_d),
    .status_q (status),
    .trig     (trig),
    .pend_nxt (pend_nxt)
  );

  irq_pulse_timer #(.PULSE_A(PULSE_A), .PULSE_B(PULSE_B), .PULSE_C(PULSE_C)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .len_code (cfg_q.len),
    .trig     (trig),
    .pend_nxt (pend_nxt),
    .active   (irq_active)
  );

  irq_pin_drv u_drv (
    .drv    (cfg_q.drv),
    .active (irq_active),
    .oe     (irq_oe),
    .val    (irq_val)
  );

  assert_reset_float_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_oe);
  assert_od_low_R6: assert property (@(posedge clk) disable iff (rst)
    ((cfg_q.drv == DRV_OPEN || cfg_q.drv == DRV_RSVD) && irq_oe) |-> !irq_val);
  assert_drive_on_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.drv == DRV_ACT_LOW || cfg_q.drv == DRV_ACT_HIGH) |-> irq_oe);
  assert_hold_level_R5: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> (irq_active == (|(status & en_q))));

endmodule

// File: tb/irq_pin_ctrl_tb_top.sv
module irq_pin_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_GEN = 3;
  localparam int NM = N_GEN + 1;
  localparam int NS = N_GEN + 2;
  localparam int WATCHDOG = 200000;

  localparam int W_OE  = 0;
  localparam int W_VAL = 1;
  localparam int W_ST  = 2;
  localparam int W_CFG = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_wr = 1'b0;
  logic [7:0]       cfg_wdata = '0;
  logic             mask_wr = 1'b0;
  logic [NM-1:0]    mask_wdata = '0;
  logic [NS-1:0]    irq_clr = '0;
  logic             sw_stim = 1'b0;
  logic [N_GEN-1:0] evt_in = '0;
  logic             cp_pseudo = 1'b0;
  logic             cp_stripe = 1'b0;
  logic [7:0]       cfg_rd;
  logic [NS-1:0]    status;
  logic             irq_oe;
  logic             irq_val;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int m = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    what;
    int    exp;
    string req;
  } item_t;
  item_t sbq[$];

  irq_pin_ctrl #(.N_GEN(N_GEN)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq_clr(irq_clr),
    .sw_stim(sw_stim), .evt_in(evt_in), .cp_pseudo(cp_pseudo),
    .cp_stripe(cp_stripe), .cfg_rd(cfg_rd), .status(status),
    .irq_oe(irq_oe), .irq_val(irq_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pop every item due at this falling edge and compare.
  always @(negedge clk) begin : monitor
    item_t it;
    int    act;
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      it = sbq.pop_front();
      case (it.what)
        W_OE:    act = int'(irq_oe);
        W_VAL:   act = int'(irq_val);
        W_ST:    act = int'(status);
        default: act = int'(cfg_rd);
      endcase
      checks++;
      if (it.cyc != cyc || act != it.exp) begin
        errors++;
        $display("FAIL %s: item %0d at cycle %0d (due %0d) actual=%0h expected=%0h",
                 it.req, it.what, cyc, it.cyc, act, it.exp);
      end
    end
  end

  task automatic push(int dc, int what, int exp, string req);
    item_t it;
    int pos;
    it.cyc = cyc + dc; it.what = what; it.exp = exp; it.req = req;
    pos = sbq.size();
    for (int k = 0; k < sbq.size(); k++) begin
      if (sbq[k].cyc > it.cyc) begin
        pos = k;
        break;
      end
    end
    sbq.insert(pos, it);
  endtask

  function automatic int exp_oe(int md, bit act);
    if (md == 1 || md == 2) return 1;
    return int'(act);
  endfunction

  function automatic int exp_val(int md, bit act);
    if (md == 1) return int'(!act);
    if (md == 2) return int'(act);
    return 0;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pin(int dc, bit act, string req);
    push(dc, W_OE, exp_oe(m, act), req);
    push(dc, W_VAL, exp_val(m, act), req);
  endtask

  // Pin active for cycles +1..+len, idle for the two after.
  task automatic expect_pulse(int len, string req);
    for (int k = 1; k <= len; k++) expect_pin(k, 1'b1, req);
    expect_pin(len + 1, 1'b0, req);
    expect_pin(len + 2, 1'b0, req);
  endtask

  task automatic expect_quiet(int n, string req);
    for (int k = 1; k <= n; k++) expect_pin(k, 1'b0, req);
  endtask

  task automatic wr_cfg(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    push(1, W_CFG, int'(v), "R12");
    step(1);
    cfg_wr = 1'b0;
    m = int'(v[1:0]);
  endtask

  task automatic wr_mask(logic [NM-1:0] v);
    mask_wr = 1'b1; mask_wdata = v;
    step(1);
    mask_wr = 1'b0;
  endtask

  task automatic clear_bits(logic [NS-1:0] v);
    irq_clr = v;
    step(1);
    irq_clr = '0;
  endtask

  task automatic fire_evt(int i);
    evt_in[i] = 1'b1;
    step(1);
    evt_in[i] = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() > 0) step(1);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    rst = 1'b0;
    // R1 reset state
    push(1, W_OE, 0, "R1");
    push(1, W_ST, 0, "R1");
    push(1, W_CFG, 8'h10, "R1");
    step(2);

    // R1: masks start disabled, status recorded but pin quiet
    push(1, W_ST, 1, "R1");
    expect_quiet(5, "R1");
    fire_evt(0);
    step(6);
    push(1, W_ST, 0, "R3");
    clear_bits('1);
    step(2);

    wr_mask('1);
    wr_cfg(8'h10);
    step(2);

    // R4/R6: short pulse, open drain
    expect_pulse(3, "R4");
    push(1, W_ST, 1, "R2");
    fire_evt(0);
    step(6);
    clear_bits('1);
    step(2);

    // R4/R7: mid pulse, active-low drive
    wr_cfg(8'h51);
    expect_pin(1, 1'b0, "R7");
    step(1);
    expect_pulse(15, "R4");
    fire_evt(1);
    step(18);
    clear_bits('1);
    step(2);

    // R4/R7: long pulse, active-high drive
    wr_cfg(8'h92);
    expect_pulse(63, "R4");
    fire_evt(2);
    step(66);
    clear_bits('1);
    step(2);

    // R6: reserved drive code acts as open drain
    wr_cfg(8'h13);
    push(1, W_OE, 0, "R6");
    step(1);
    expect_pulse(3, "R6");
    fire_evt(0);
    step(6);
    clear_bits('1);
    step(2);

    // R8: no retrigger while enabled bits pending
    wr_cfg(8'h12);
    expect_pulse(3, "R8");
    fire_evt(0);
    step(5);
    expect_quiet(6, "R8");
    push(1, W_ST, 5'b00011, "R8");
    fire_evt(1);
    step(6);
    push(1, W_ST, 5'b00010, "R3");
    clear_bits(5'b00001);
    step(1);
    expect_quiet(5, "R8");
    push(1, W_ST, 5'b00110, "R8");
    fire_evt(2);
    step(5);
    clear_bits('1);
    step(2);
    // R9: fresh pulse once everything is clear
    expect_pulse(3, "R9");
    fire_evt(1);
    step(5);

    // R3: set beats clear in the same cycle; R9 cleared-same-cycle retriggers
    evt_in[0] = 1'b1;
    irq_clr = 5'b00011;
    push(1, W_ST, 5'b00001, "R3");
    expect_pulse(3, "R9");
    step(1);
    evt_in[0] = 1'b0;
    irq_clr = '0;
    step(5);
    clear_bits('1);
    step(2);

    // R5: hold until cleared
    wr_cfg(8'hD2);
    evt_in[2] = 1'b1;
    for (int k = 1; k <= 4; k++) expect_pin(k, 1'b1, "R5");
    step(4);
    evt_in[2] = 1'b0;
    for (int k = 1; k <= 4; k++) expect_pin(k, 1'b1, "R5");
    step(4);
    expect_pin(1, 1'b0, "R5");
    expect_pin(2, 1'b0, "R5");
    clear_bits(5'b00100);
    step(2);
    // R5: masking the pending bit also releases it
    expect_pin(1, 1'b1, "R5");
    fire_evt(2);
    step(2);
    expect_pin(1, 1'b0, "R5");
    push(1, W_ST, 5'b00100, "R5");
    wr_mask(4'b1011);
    step(2);
    expect_pin(1, 1'b1, "R5");
    wr_mask('1);
    step(2);
    expect_pin(1, 1'b0, "R5");
    clear_bits('1);
    step(2);

    // R10: software stimulus, unaffected by masks
    wr_cfg(8'h12);
    sw_stim = 1'b1;
    push(1, W_ST, 5'b10000, "R10");
    expect_pulse(3, "R10");
    step(1);
    sw_stim = 1'b0;
    step(5);
    clear_bits('1);
    wr_mask('0);
    step(2);
    sw_stim = 1'b1;
    expect_pulse(3, "R10");
    step(1);
    sw_stim = 1'b0;
    step(5);
    clear_bits('1);
    wr_mask('1);
    step(2);

    // R11: copy-protection source select
    cp_stripe = 1'b1;
    push(1, W_ST, 0, "R11");
    expect_quiet(3, "R11");
    step(3);
    cp_stripe = 1'b0;
    step(2);
    cp_pseudo = 1'b1;
    push(1, W_ST, 5'b01000, "R11");
    expect_pulse(3, "R11");
    step(1);
    cp_pseudo = 1'b0;
    step(5);
    clear_bits('1);
    step(2);

    wr_cfg(8'h22);
    step(1);
    cp_pseudo = 1'b1;
    push(1, W_ST, 0, "R11");
    expect_quiet(3, "R11");
    step(3);
    cp_pseudo = 1'b0;
    step(2);
    cp_stripe = 1'b1;
    push(1, W_ST, 5'b01000, "R11");
    expect_pulse(3, "R11");
    step(1);
    cp_stripe = 1'b0;
    step(5);
    clear_bits('1);
    step(2);

    wr_cfg(8'h32);
    step(1);
    cp_pseudo = 1'b1;
    push(1, W_ST, 5'b01000, "R11");
    step(1);
    cp_pseudo = 1'b0;
    step(5);
    clear_bits('1);
    step(2);
    cp_stripe = 1'b1;
    push(1, W_ST, 5'b01000, "R11");
    expect_pulse(3, "R11");
    step(1);
    cp_stripe = 1'b0;
    step(5);
    clear_bits('1);
    step(2);

    wr_cfg(8'h02);
    step(1);
    cp_pseudo = 1'b1;
    cp_stripe = 1'b1;
    push(1, W_ST, 0, "R11");
    expect_quiet(3, "R11");
    step(3);
    cp_pseudo = 1'b0;
    cp_stripe = 1'b0;
    step(2);

    drain();
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule